// File: doc/BRIEF.md
# Printer Port Register Emulator

This block presents a standard-mode printer port to a host as three byte registers on a simple synchronous register bus. The printer handshake is modelled inside the block rather than driven on pins. The busy and acknowledge status bits are stepped by host accesses. A strobe sequence in the control register sends the written data byte out on a one-cycle byte-valid stream. A level interrupt output reports a pending acknowledge event.

The host issues single-cycle read or write strobes with an address and a data byte. Read data is returned combinationally in the same cycle as the read strobe. Register updates and read side effects take place at that clock edge. A separate load strobe captures an incoming byte into the read latch, which the host sees through the data register when the direction bit is set. Only the low three address bits are decoded, so the register set repeats through the whole address space.

Top module: `prt_port_emu`

## Requirements
- R1: Only address bits 2:0 are decoded; higher bits are ignored. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF, and writes to offsets 1 and 3 to 7 change no state. Read and write strobes are never active in the same cycle.
- R2: After reset the write latch and read latch hold 0xFF, status reads 0xD9, control reads 0xCC, and irq and tx_valid are 0.
- R3: A control write stores the written byte with bits 7:6 forced to 1, and a control read returns it. The control bits are: bit5 direction (1 = host reads), bit4 interrupt enable, bit3 select, bit2 init, bit1 auto-linefeed, bit0 strobe.
- R4: A control write with bit2 (init) at 0 loads status with 0xD8: busy bit7, acknowledge bit6, online bit4 and error bit3 set, all other bits clear. It emits no byte and leaves the interrupt state unchanged, whatever the select and strobe bits are.
- R5: A control write with init 1, select 1 and strobe 1 clears status bit7. If bit0 of the previous control value was 0, tx_valid is 1 for exactly the cycle after the write, with tx_data equal to the write latch.
- R6: A control write with init 1, select 1 and strobe 0 sets interrupt-pending when bit4 of the previous control value is 1. irq equals the pending flag and rises in the cycle after that write.
- R7: A data read returns the read latch when control bit5 is 1, and the write latch otherwise. rx_load captures rx_byte into the read latch. A data write changes only the write latch and emits no byte.
- R8: A status read returns the current status in the same cycle, and irq is 0 from the next cycle. The status is also stepped when status bit7 is 0 and control bit0 is 0: bit6 is cleared if it was 1; otherwise bits 7 and 6 are both set. In all other cases the status is left unchanged.
- R9: A control write with init 1 and select 0 changes only the control value: status, irq and tx_valid are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Register address, low three bits decoded |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| rx_load | input | 1 | Load strobe for the read latch |
| rx_byte | input | 8 | Byte captured by rx_load |
| tx_valid | output | 1 | One-cycle pulse marking an emitted byte |
| tx_data | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The properties assume that the host never raises read and write in the same cycle, since the side effects of a combined access are not defined. An assertion flags any violation of this rule. The stimulus drives exactly one bus strobe per access cycle, and rx_load is the only strobe that may overlap a bus access. The properties also assume that every strobe is sampled for a single edge. The bench therefore clears all strobes immediately after the edge that consumes them, including during the randomized phase.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int unsigned ST_BUSY_N = 7;
  localparam int unsigned ST_ACK    = 6;
  localparam int unsigned ST_ONLINE = 4;
  localparam int unsigned ST_ERR_N  = 3;
  localparam int unsigned ST_TMO    = 0;

  // control bit positions
  localparam int unsigned CT_DIR  = 5;
  localparam int unsigned CT_IE   = 4;
  localparam int unsigned CT_SEL  = 3;
  localparam int unsigned CT_INIT = 2;
  localparam int unsigned CT_STB  = 0;

  localparam logic [BYTE_W-1:0] CT_FORCED = 8'hC0;
  localparam logic [BYTE_W-1:0] LATCH_RST = 8'hFF;
  localparam logic [BYTE_W-1:0] UNDEC_RD  = 8'hFF;

  localparam logic [BYTE_W-1:0] ST_IDLE =
    (BYTE_W'(1) << ST_BUSY_N) | (BYTE_W'(1) << ST_ACK) |
    (BYTE_W'(1) << ST_ONLINE) | (BYTE_W'(1) << ST_ERR_N);
  localparam logic [BYTE_W-1:0] ST_RST = ST_IDLE | (BYTE_W'(1) << ST_TMO);
  localparam logic [BYTE_W-1:0] CT_RST =
    CT_FORCED | (BYTE_W'(1) << CT_SEL) | (BYTE_W'(1) << CT_INIT);

  typedef struct packed {
    logic data;
    logic stat;
    logic ctrl;
  } reg_sel_t;
endpackage

// File: rtl/prt_decode.sv
module prt_decode
  import prt_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output reg_sel_t      wsel,
  output reg_sel_t      rsel
);
  logic [2:0] off;
  logic       rd_eff;

  assign off    = addr[2:0];
  assign rd_eff = rd & ~wr;

  generate
    if (AW > 3) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[AW-1:3];
    end
  endgenerate

  always_comb begin
    wsel.data = wr && (off == OFF_DATA);
    wsel.stat = 1'b0;
    wsel.ctrl = wr && (off == OFF_CTRL);
    rsel.data = rd_eff && (off == OFF_DATA);
    rsel.stat = rd_eff && (off == OFF_STAT);
    rsel.ctrl = rd_eff && (off == OFF_CTRL);
  end
endmodule

// File: rtl/prt_data_latch.sv
module prt_data_latch
  import prt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] dataw_q,
  output logic [BYTE_W-1:0] datar_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dataw_q <= LATCH_RST;
      datar_q <= LATCH_RST;
    end else begin
      if (wr_data) dataw_q <= wdata;
      if (rx_load) datar_q <= rx_byte;
    end
  end
endmodule

// File: rtl/prt_hshake.sv
module prt_hshake
  import prt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] dataw_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              pend_q,
  output logic              tx_valid_q,
  output logic [BYTE_W-1:0] tx_data_q
);
  logic [BYTE_W-1:0] ctrl_in, ctrl_n, stat_n;
  logic              pend_n, emit;

  assign ctrl_in = wdata | CT_FORCED;

  always_comb begin
    ctrl_n = ctrl_q;
    stat_n = stat_q;
    pend_n = pend_q;
    emit   = 1'b0;
    if (wr_ctrl) begin
      ctrl_n = ctrl_in;
      if (!ctrl_in[CT_INIT]) begin
        stat_n = ST_IDLE;
      end else if (ctrl_in[CT_SEL]) begin
        if (ctrl_in[CT_STB]) begin
          stat_n[ST_BUSY_N] = 1'b0;
          emit = ~ctrl_q[CT_STB];
        end else if (ctrl_q[CT_IE]) begin
          pend_n = 1'b1;
        end
      end
    end else if (rd_stat) begin
      pend_n = 1'b0;
      if (!stat_q[ST_BUSY_N] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_n[ST_ACK] = 1'b0;
        end else begin
          stat_n[ST_ACK]    = 1'b1;
          stat_n[ST_BUSY_N] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= CT_RST;
      stat_q     <= ST_RST;
      pend_q     <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      ctrl_q     <= ctrl_n;
      stat_q     <= stat_n;
      pend_q     <= pend_n;
      tx_valid_q <= emit;
      if (emit) tx_data_q <= dataw_q;
    end
  end
endmodule

// File: rtl/prt_rdmux.sv
module prt_rdmux
  import prt_pkg::*;
(
  input  reg_sel_t          rsel,
  input  logic [BYTE_W-1:0] dataw_q,
  input  logic [BYTE_W-1:0] datar_q,
  input  logic [BYTE_W-1:0] stat_q,
  input  logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    rdata = UNDEC_RD;
    if (rsel.data)      rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
    else if (rsel.stat) rdata = stat_q;
    else if (rsel.ctrl) rdata = ctrl_q;
  end
endmodule

// File: rtl/prt_port_emu.sv
module prt_port_emu
  import prt_pkg::*;
#(
  parameter int unsigned BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  reg_sel_t          wsel, rsel;
  logic [BYTE_W-1:0] dataw_q, datar_q, ctrl_q, stat_q;
  logic              pend_q;
  logic              unused_wsel_stat;

  assign unused_wsel_stat = wsel.stat;

  prt_decode #(.AW(BUS_AW)) u_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .wsel (wsel),
    .rsel (rsel)
  );

  prt_data_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wsel.data),
    .wdata   (bus_wdata),
    .rx_load (rx_load),
    .rx_byte (rx_byte),
    .dataw_q (dataw_q),
    .datar_q (datar_q)
  );

  prt_hshake u_hshake (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (wsel.ctrl),
    .rd_stat    (rsel.stat),
    .wdata      (bus_wdata),
    .dataw_q    (dataw_q),
    .ctrl_q     (ctrl_q),
    .stat_q     (stat_q),
    .pend_q     (pend_q),
    .tx_valid_q (tx_valid),
    .tx_data_q  (tx_data)
  );

  prt_rdmux u_rdmux (
    .rsel    (rsel),
    .dataw_q (dataw_q),
    .datar_q (datar_q),
    .stat_q  (stat_q),
    .ctrl_q  (ctrl_q),
    .rdata   (bus_rdata)
  );

  assign irq = pend_q;
endmodule

// File: rtl/prt_port_emu_chk.sv
module prt_port_emu_chk #(
  parameter int unsigned BUS_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              irq,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        stat_q,
  input logic [7:0]        dataw_q
);
  logic [2:0] off;
  logic       chk_unused;
  assign off        = bus_addr[2:0];
  assign chk_unused = ^bus_addr;

  assert_single_access_R1: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  assert_undecoded_read_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && off > 3'd2) |-> bus_rdata == 8'hFF);

  assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 3'd2) |=> ctrl_q == ($past(bus_wdata) | 8'hC0));

  assert_init_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 3'd2 && !bus_wdata[2]) |=> (stat_q == 8'hD8 && !tx_valid));

  assert_tx_single_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  assert_tx_cause_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ($past(bus_wr && off == 3'd2 && bus_wdata[2] && bus_wdata[3]
                        && bus_wdata[0] && !ctrl_q[0])
                  && tx_data == $past(dataw_q)));

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && off == 3'd1) |=> !irq);

  assert_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && off == 3'd2 && bus_wdata[2] && !bus_wdata[3])
      |=> (stat_q == $past(stat_q) && irq == $past(irq) && !tx_valid));
endmodule

bind prt_port_emu prt_port_emu_chk #(.BUS_AW(BUS_AW)) u_chk (.*);

// File: tb/prt_port_emu_bench.sv
module prt_port_emu_bench;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, rx_load = 1'b0;
  logic [7:0]    bus_wdata = '0, rx_byte = '0;
  logic [7:0]    bus_rdata, tx_data;
  logic          tx_valid, irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference model state
  bit [7:0] m_dw, m_dr, m_st, m_ct, m_txd;
  bit       m_pend, m_txv;

  always #5 clk = ~clk;

  prt_port_emu #(.BUS_AW(AW)) u_prt_port_emu (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_load(rx_load),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] m_read(bit [2:0] a);
    case (a)
      3'd0: return m_ct[5] ? m_dr : m_dw;
      3'd1: return m_st;
      3'd2: return m_ct;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic m_reset();
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC;
    m_pend = 0; m_txv = 0; m_txd = 0;
  endtask

  task automatic m_step(bit wr, bit rd, bit [2:0] a, bit [7:0] wd, bit ld, bit [7:0] rb);
    bit [7:0] v;
    m_txv = 0;
    if (wr) begin
      if (a == 3'd0) m_dw = wd;
      else if (a == 3'd2) begin
        v = wd | 8'hC0;
        if (!v[2]) m_st = 8'hD8;
        else if (v[3]) begin
          if (v[0]) begin
            m_st[7] = 0;
            if (!m_ct[0]) begin m_txv = 1; m_txd = m_dw; end
          end else if (m_ct[4]) m_pend = 1;
        end
        m_ct = v;
      end
    end else if (rd && a == 3'd1) begin
      m_pend = 0;
      if (!m_st[7] && !m_ct[0]) begin
        if (m_st[6]) m_st[6] = 0;
        else m_st[7:6] = 2'b11;
      end
    end
    if (ld) m_dr = rb;
  endtask

  // one clock of stimulus, compared against the model
  task automatic cyc(string tag, bit wr, bit rd, bit [AW-1:0] a, bit [7:0] wd,
                     bit ld = 0, bit [7:0] rb = 0);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    rx_load = ld; rx_byte = rb;
    #1;
    if (rd) chk(tag, "rdata", int'(bus_rdata), int'(m_read(a[2:0])));
    m_step(wr, rd, a[2:0], wd, ld, rb);
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; rx_load = 0;
    chk(tag, "tx_valid", int'(tx_valid), int'(m_txv));
    if (m_txv) chk(tag, "tx_data", int'(tx_data), int'(m_txd));
    chk(tag, "irq", int'(irq), int'(m_pend));
  endtask

  task automatic wr_reg(string tag, bit [AW-1:0] a, bit [7:0] d);
    cyc(tag, 1, 0, a, d);
  endtask

  task automatic rd_reg(string tag, bit [AW-1:0] a);
    cyc(tag, 0, 1, a, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_reset();
    cyc("R2", 0, 0, 0, 0);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 reset values
    rd_reg("R2", 8'h02);
    rd_reg("R2", 8'h01);
    rd_reg("R2", 8'h00);
    // R1 holes and aliasing
    for (int i = 3; i < 8; i++) rd_reg("R1", AW'(i));
    rd_reg("R1", 8'h0A);
    rd_reg("R1", 8'hF9);
    wr_reg("R1", 8'h01, 8'h00);
    wr_reg("R1", 8'h05, 8'h12);
    rd_reg("R1", 8'h01);
    rd_reg("R1", 8'h02);
    rd_reg("R1", 8'h00);
    // R7 data latches
    wr_reg("R7", 8'h00, 8'h5A);
    rd_reg("R7", 8'h00);
    cyc("R7", 0, 0, 0, 0, 1, 8'h3C);
    rd_reg("R7", 8'h00);
    wr_reg("R3", 8'h02, 8'h2C);
    rd_reg("R3", 8'h02);
    rd_reg("R7", 8'h00);
    // R5 strobe sequence and R8 status stepping
    wr_reg("R5", 8'h02, 8'h0C);
    wr_reg("R5", 8'h02, 8'h0D);
    rd_reg("R8", 8'h01);
    wr_reg("R5", 8'h02, 8'h0C);
    rd_reg("R8", 8'h01);
    rd_reg("R8", 8'h01);
    rd_reg("R8", 8'h01);
    wr_reg("R7", 8'h08, 8'hA5);
    wr_reg("R5", 8'h02, 8'h0D);
    wr_reg("R5", 8'h02, 8'h0D);
    rd_reg("R5", 8'h01);
    // R6 interrupt
    wr_reg("R6", 8'h02, 8'h1C);
    wr_reg("R6", 8'h02, 8'h1C);
    wr_reg("R6", 8'h00, 8'h77);
    cyc("R6", 0, 0, 0, 0);
    rd_reg("R8", 8'h01);
    // R4 init reload
    wr_reg("R4", 8'h02, 8'h1C);
    wr_reg("R4", 8'h02, 8'h1D);
    wr_reg("R4", 8'h02, 8'h18);
    wr_reg("R4", 8'h02, 8'h19);
    rd_reg("R4", 8'h01);
    // R9 deselected
    wr_reg("R9", 8'h02, 8'h1C);
    wr_reg("R9", 8'h02, 8'h1C);
    wr_reg("R9", 8'h02, 8'h05);
    wr_reg("R9", 8'h02, 8'h04);
    rd_reg("R9", 8'h01);
    rd_reg("R9", 8'h02);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 7);
      bit [7:0] d = 8'($urandom);
      bit [AW-1:0] hi = AW'($urandom) & ~AW'(7);
      case (op)
        0: wr_reg("R7", hi | 0, d);
        1, 2: wr_reg("R5", hi | 2, d);
        3: rd_reg("R8", hi | 1);
        4: rd_reg("R7", hi | 0);
        5: rd_reg("R3", hi | 2);
        6: rd_reg("R1", hi | AW'($urandom_range(3, 7)));
        default: cyc("R7", 0, 0, hi, 0, 1, d);
      endcase
    end
    // reset in the middle of activity
    wr_reg("R6", 8'h02, 8'h1C);
    wr_reg("R6", 8'h02, 8'h1C);
    do_reset();
    rd_reg("R2", 8'h02);
    rd_reg("R2", 8'h01);
    rd_reg("R2", 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule